// File: doc/BRIEF.md
# Frame-aware receive FIFO

This block is a byte-wide buffer between the receive side of an Ethernet MAC and the consumer that moves frames into memory. The writer pushes one byte per cycle and cannot be stalled. It marks the final byte of each frame and supplies a status word with that final byte. The reader takes bytes through a valid/ready handshake, with flags for the first and last byte of each frame. After each frame's last byte, the reader takes that frame's status word through a second valid/ready handshake. Byte data and status words are held in separate queues, and both queues keep frames in arrival order.

A configuration input selects one of two readout modes. In store-and-forward mode, no byte of a frame can be read until the whole frame has been written. If error dropping is also enabled, a frame whose status shows an error is removed by moving the write pointer back to where that frame started. In cut-through mode, bytes can be read while the frame is still arriving. Errored frames are then delivered in full, and the status word reports the error. The newest byte of an open frame is held back from the reader. This keeps the end marker correct if the frame must be cut short.

If the byte buffer fills partway through a frame, the frame is cut short. Its last stored byte becomes its final byte, its status is replaced by an overflow status, and the writer gets a one-cycle drop pulse. If there is no room when a frame starts, the whole frame is ignored. The configuration inputs are expected to change only while the buffer is empty and no frame is being written.

Top module: `frame_rx_fifo`

## Requirements
- R1: After reset, `rd_valid`, `st_valid` and `wr_drop` are low.
- R2: In store-and-forward mode (`cfg_store_fwd`=1), `rd_valid` stays low while a frame is partly written. It rises in the cycle after the byte with `wr_last` is accepted.
- R3: In store-and-forward mode with `cfg_drop_err`=1, a frame whose end status has bit 0 set (the error bit) is discarded. None of its bytes and no status word ever reach the read side.
- R4: In store-and-forward mode with `cfg_drop_err`=0, an errored frame is delivered in full, and its status still has bit 0 set.
- R5: In cut-through mode (`cfg_store_fwd`=0), bytes of an open frame can be read before the frame ends. After N bytes of an open frame have been written, exactly N-1 of them can be read. The last written byte becomes readable once the frame ends.
- R6: In cut-through mode, an errored frame is delivered in full even when `cfg_drop_err`=1, and its status has bit 0 set.
- R7: A byte transfers only when `rd_valid` and `rd_ready` are both high, and an offered byte is held unchanged until it transfers. `rd_first` is high on a frame's first byte and `rd_last` on its final byte.
- R8: After a frame's final byte transfers, `rd_valid` is low and `st_valid` is high until the status handshake completes. `st_data` is {overflow bit, writer status}, and the overflow bit is the MSB.
- R9: If a byte of an open frame arrives while the byte buffer is full, the frame ends at its last stored byte and its status is 0x100 (overflow bit set, writer status zero). `wr_drop` is high for one cycle, in the cycle after the rejected byte. The frame's remaining bytes are ignored.
- R10: If a frame's first byte arrives while the byte buffer or the status queue is full, the whole frame is ignored and no status is queued. `wr_drop` pulses for one cycle.
- R11: Several complete frames can be queued, and they are read out with their status words in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_store_fwd | input | 1 | 1 selects store-and-forward, 0 selects cut-through |
| cfg_drop_err | input | 1 | Discard errored frames (store-and-forward only) |
| wr_valid | input | 1 | Byte present on the write side |
| wr_data | input | DATA_W | Frame byte |
| wr_last | input | 1 | This byte ends the frame |
| wr_status | input | STAT_W | Frame status, sampled with `wr_last`; bit 0 is the error bit |
| wr_drop | output | 1 | One-cycle pulse when a frame is cut short or ignored |
| rd_valid | output | 1 | A byte is offered |
| rd_ready | input | 1 | Consumer accepts the offered byte |
| rd_data | output | DATA_W | Offered byte |
| rd_first | output | 1 | Offered byte is the first of its frame |
| rd_last | output | 1 | Offered byte is the final byte of its frame |
| st_valid | output | 1 | A status word is offered |
| st_ready | input | 1 | Consumer accepts the status word |
| st_data | output | STAT_W+1 | {overflow, writer status} |

## Verification
The hardest case to reach from the ports is an overflow partway through a frame in cut-through mode. In that case the held-back newest byte must be marked as the frame's end after it has been written. The bench gets there by keeping `rd_ready` low and writing a frame longer than the buffer. It then checks that the pulse comes after exactly the byte that found the buffer full, and that the frame's end falls on the last stored byte. Both start-of-frame rejections are reached separately: filling the status queue with short frames, and filling the byte buffer with a frame of exactly its depth.

// File: rtl/frx_pkg.sv
package frx_pkg;
   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_OPEN = 2'd1,
      WS_SKIP = 2'd2
   } wr_state_e;

   localparam int ERR_BIT = 0;
endpackage

// File: rtl/frx_byte_store.sv
module frx_byte_store #(
   parameter int DATA_W = 8,
   parameter int AW     = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wlast,
   input  logic              mark_we,
   input  logic [AW-1:0]     mark_addr,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata,
   output logic              rlast
);
   localparam int DEPTH = 1 << AW;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]  endf;
   logic [DEPTH-1:0]  endf_nx;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // end-of-frame flags: normal write or a later mark when a frame is cut short
   for (genvar g = 0; g < DEPTH; g++) begin : g_endf
      assign endf_nx[g] = (we && waddr == AW'(g)) ? wlast :
                          (mark_we && mark_addr == AW'(g)) ? 1'b1 : endf[g];
   end

   always_ff @(posedge clk) begin
      endf <= endf_nx;
   end

   assign rdata = mem[raddr];
   assign rlast = endf[raddr];
endmodule

// File: rtl/frx_stat_queue.sv
module frx_stat_queue #(
   parameter int W  = 9,
   parameter int AW = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int DEPTH = 1 << AW;
   localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

   logic [W-1:0] q [DEPTH];
   logic [AW:0]  wp, rp;

   assign full  = (wp - rp) == FULL_CNT;
   assign empty = (wp == rp);
   assign dout  = q[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push) q[wp[AW-1:0]] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
      end
   end

   assert_push_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   assert_pop_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/frx_write_ctl.sv
module frx_write_ctl
   import frx_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_sf,
   input  logic          cfg_drop,
   input  logic          wr_valid,
   input  logic          wr_last,
   input  logic          wr_err,
   input  logic [AW:0]   rd_ptr,
   input  logic          sq_full,
   output logic          mem_we,
   output logic [AW-1:0] mem_waddr,
   output logic          mark_we,
   output logic [AW-1:0] mark_addr,
   output logic          sq_push,
   output logic          sq_ovf,
   output logic [AW:0]   rd_limit,
   output logic          wr_drop
);
   localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

   wr_state_e   st;
   logic [AW:0] wr_ptr, wr_sof, commit;
   logic        data_full, kill_err, start_ok, drop_now;

   assign data_full = (wr_ptr - rd_ptr) == FULL_CNT;
   assign kill_err  = cfg_sf && cfg_drop && wr_err;
   assign start_ok  = !data_full && !sq_full;
   assign mem_waddr = wr_ptr[AW-1:0];
   assign mark_addr = wr_ptr[AW-1:0] - 1'b1;

   always_comb begin
      mem_we   = 1'b0;
      mark_we  = 1'b0;
      sq_push  = 1'b0;
      sq_ovf   = 1'b0;
      drop_now = 1'b0;
      if (wr_valid) begin
         unique case (st)
            WS_IDLE: begin
               if (start_ok) begin
                  mem_we  = 1'b1;
                  sq_push = wr_last && !kill_err;
               end else begin
                  drop_now = 1'b1;
               end
            end
            WS_OPEN: begin
               if (data_full) begin
                  mark_we  = 1'b1;
                  sq_push  = 1'b1;
                  sq_ovf   = 1'b1;
                  drop_now = 1'b1;
               end else begin
                  mem_we  = 1'b1;
                  sq_push = wr_last && !kill_err;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= WS_IDLE;
         wr_ptr  <= '0;
         wr_sof  <= '0;
         commit  <= '0;
         wr_drop <= 1'b0;
      end else begin
         wr_drop <= drop_now;
         if (wr_valid) begin
            unique case (st)
               WS_IDLE: begin
                  if (start_ok) begin
                     wr_sof <= wr_ptr;
                     if (!wr_last) begin
                        wr_ptr <= wr_ptr + 1'b1;
                        st     <= WS_OPEN;
                     end else if (!kill_err) begin
                        wr_ptr <= wr_ptr + 1'b1;
                        commit <= wr_ptr + 1'b1;
                     end
                  end else if (!wr_last) begin
                     st <= WS_SKIP;
                  end
               end
               WS_OPEN: begin
                  if (data_full) begin
                     commit <= wr_ptr;
                     st     <= wr_last ? WS_IDLE : WS_SKIP;
                  end else if (wr_last) begin
                     st <= WS_IDLE;
                     if (kill_err) begin
                        wr_ptr <= wr_sof;
                     end else begin
                        wr_ptr <= wr_ptr + 1'b1;
                        commit <= wr_ptr + 1'b1;
                     end
                  end else begin
                     wr_ptr <= wr_ptr + 1'b1;
                  end
               end
               default: if (wr_last) st <= WS_IDLE;
            endcase
         end
      end
   end

   // store-and-forward exposes completed frames only; cut-through holds the newest byte
   assign rd_limit = cfg_sf ? commit : ((st == WS_OPEN) ? wr_ptr - 1'b1 : wr_ptr);

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr - rd_ptr) <= FULL_CNT);
   assert_limit_inside_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_limit - rd_ptr) <= (wr_ptr - rd_ptr));
   assert_rewind_only_on_error_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr != $past(wr_ptr) && wr_ptr != $past(wr_ptr) + 1'b1)
      |-> $past(cfg_sf && cfg_drop && wr_valid && wr_last && wr_err));
endmodule

// File: rtl/frame_rx_fifo.sv
module frame_rx_fifo
   import frx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int STAT_W = 8,
   parameter int BUF_AW = 4,
   parameter int SQ_AW  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_store_fwd,
   input  logic              cfg_drop_err,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_last,
   input  logic [STAT_W-1:0] wr_status,
   output logic              wr_drop,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_first,
   output logic              rd_last,
   output logic              st_valid,
   input  logic              st_ready,
   output logic [STAT_W:0]   st_data
);
   localparam int SW = STAT_W + 1;

   initial begin
      assert (BUF_AW >= 2) else $error("BUF_AW must be at least 2");
      assert (SQ_AW >= 1)  else $error("SQ_AW must be at least 1");
      assert (STAT_W > ERR_BIT) else $error("STAT_W too small for error bit");
   end

   logic              mem_we, mark_we, sq_push, sq_ovf, sq_full, sq_empty, sq_pop;
   logic [BUF_AW-1:0] mem_waddr, mark_addr;
   logic [BUF_AW:0]   rd_ptr, rd_limit;
   logic [SW-1:0]     sq_din;
   logic              st_pend, at_first;

   frx_write_ctl #(.AW(BUF_AW)) u_wctl (
      .clk(clk), .rst_n(rst_n),
      .cfg_sf(cfg_store_fwd), .cfg_drop(cfg_drop_err),
      .wr_valid(wr_valid), .wr_last(wr_last), .wr_err(wr_status[ERR_BIT]),
      .rd_ptr(rd_ptr), .sq_full(sq_full),
      .mem_we(mem_we), .mem_waddr(mem_waddr),
      .mark_we(mark_we), .mark_addr(mark_addr),
      .sq_push(sq_push), .sq_ovf(sq_ovf),
      .rd_limit(rd_limit), .wr_drop(wr_drop)
   );

   frx_byte_store #(.DATA_W(DATA_W), .AW(BUF_AW)) u_store (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data), .wlast(wr_last),
      .mark_we(mark_we), .mark_addr(mark_addr),
      .raddr(rd_ptr[BUF_AW-1:0]), .rdata(rd_data), .rlast(rd_last)
   );

   assign sq_din = sq_ovf ? {1'b1, {STAT_W{1'b0}}} : {1'b0, wr_status};
   assign sq_pop = st_valid && st_ready;

   frx_stat_queue #(.W(SW), .AW(SQ_AW)) u_stq (
      .clk(clk), .rst_n(rst_n), .push(sq_push), .din(sq_din), .pop(sq_pop),
      .dout(st_data), .full(sq_full), .empty(sq_empty)
   );

   assign rd_valid = (rd_ptr != rd_limit) && !st_pend;
   assign rd_first = at_first;
   assign st_valid = st_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr   <= '0;
         st_pend  <= 1'b0;
         at_first <= 1'b1;
      end else begin
         if (rd_valid && rd_ready) begin
            rd_ptr   <= rd_ptr + 1'b1;
            at_first <= rd_last;
            if (rd_last) st_pend <= 1'b1;
         end
         if (sq_pop) st_pend <= 1'b0;
      end
   end

   assert_status_follows_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && rd_ready && rd_last |=> st_valid && !rd_valid);
   assert_status_backed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> !sq_empty);
   assert_hold_offer_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_last));
endmodule

// File: tb/sim_frame_rx_fifo.sv
module sim_frame_rx_fifo;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_store_fwd = 1'b1, cfg_drop_err = 1'b1;
   logic       wr_valid = 1'b0, wr_last = 1'b0;
   logic [7:0] wr_data = '0, wr_status = '0;
   logic       wr_drop, rd_valid, rd_first, rd_last, st_valid;
   logic       rd_ready = 1'b0, st_ready = 1'b0;
   logic [7:0] rd_data;
   logic [8:0] st_data;

   int nchk = 0, nerr = 0, cyc = 0;

   always #2 clk = ~clk;

   frame_rx_fifo u0 (
      .clk(clk), .rst_n(rst_n), .cfg_store_fwd(cfg_store_fwd), .cfg_drop_err(cfg_drop_err),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_status(wr_status),
      .wr_drop(wr_drop), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
      .rd_first(rd_first), .rd_last(rd_last), .st_valid(st_valid), .st_ready(st_ready),
      .st_data(st_data)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         nchk++; nerr++;
         $display("FAIL R11 watchdog: cycles=%0d expected below 20000", cyc);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // called at a negedge; returns at a negedge
   task automatic write_frame(input int len, input int base, input logic [7:0] stat,
                              output int ndrop, output int first_drop);
      ndrop = 0; first_drop = -1;
      for (int i = 0; i < len; i++) begin
         wr_valid = 1'b1; wr_data = 8'(base + i); wr_last = (i == len - 1); wr_status = stat;
         @(negedge clk);
         if (wr_drop) begin
            if (first_drop < 0) first_drop = i;
            ndrop++;
         end
      end
      wr_valid = 1'b0; wr_last = 1'b0;
      @(negedge clk);
      if (wr_drop) ndrop++;
   endtask

   task automatic pop_byte(output bit ok, output logic [7:0] d, output logic f, output logic l);
      int t = 0;
      while (!rd_valid && t < 20) begin @(negedge clk); t++; end
      ok = rd_valid; d = rd_data; f = rd_first; l = rd_last;
      if (ok) begin rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0; end
   endtask

   task automatic pop_stat(input string req, input int exp);
      int t = 0;
      while (!st_valid && t < 20) begin @(negedge clk); t++; end
      chk(req, "status offered", int'(st_valid), 1);
      chk(req, "status word", int'(st_data), exp);
      if (st_valid) begin st_ready = 1'b1; @(negedge clk); st_ready = 1'b0; end
   endtask

   task automatic read_frame(input string req, input int len, input int base, input int exp_st);
      bit ok; logic [7:0] d; logic f, l;
      for (int i = 0; i < len; i++) begin
         pop_byte(ok, d, f, l);
         chk(req, "byte offered", int'(ok), 1);
         chk(req, "byte value", int'(d), (base + i) & 8'hff);
         chk("R7", "first flag", int'(f), int'(i == 0));
         chk("R7", "last flag", int'(l), int'(i == len - 1));
      end
      pop_stat(req, exp_st);
   endtask

   task automatic chk_empty(input string req);
      @(negedge clk); @(negedge clk);
      chk(req, "no byte left", int'(rd_valid), 0);
      chk(req, "no status left", int'(st_valid), 0);
   endtask

   // {sf, drop, deliver, len[4:0], base[7:0], status[7:0], pad[7:0]}
   localparam logic [31:0] VECS [8] = '{
      {1'b1, 1'b1, 1'b1, 5'd4,  8'h10, 8'h02, 8'h00},  // R3 clean frame kept
      {1'b1, 1'b1, 1'b0, 5'd5,  8'h20, 8'h03, 8'h00},  // R3 errored frame discarded
      {1'b1, 1'b0, 1'b1, 5'd3,  8'h30, 8'h05, 8'h00},  // R4 errored frame kept
      {1'b0, 1'b1, 1'b1, 5'd6,  8'h40, 8'h01, 8'h00},  // R6 cut-through errored
      {1'b0, 1'b0, 1'b1, 5'd1,  8'h50, 8'h00, 8'h00},  // R6 single byte
      {1'b1, 1'b1, 1'b1, 5'd1,  8'h60, 8'h80, 8'h00},  // R8 status high bits
      {1'b1, 1'b1, 1'b0, 5'd1,  8'h70, 8'h81, 8'h00},  // R3 single errored byte
      {1'b0, 1'b1, 1'b1, 5'd16, 8'h80, 8'h40, 8'h00}   // R7 frame of full depth
   };

   initial begin
      int nd, fd;
      bit ok; logic [7:0] d; logic f, l;

      repeat (3) @(negedge clk);
      chk("R1", "rd_valid after reset", int'(rd_valid), 0);
      chk("R1", "st_valid after reset", int'(st_valid), 0);
      chk("R1", "wr_drop after reset", int'(wr_drop), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "rd_valid out of reset", int'(rd_valid), 0);

      foreach (VECS[k]) begin
         cfg_store_fwd = VECS[k][31];
         cfg_drop_err  = VECS[k][30];
         @(negedge clk);
         write_frame(int'(VECS[k][28:24]), int'(VECS[k][23:16]), VECS[k][15:8], nd, fd);
         chk("R10", "no drop pulse", nd, 0);
         if (VECS[k][29])
            read_frame(VECS[k][31] ? (VECS[k][30] ? "R3" : "R4") : "R6",
                       int'(VECS[k][28:24]), int'(VECS[k][23:16]), int'({1'b0, VECS[k][15:8]}));
         chk_empty(VECS[k][29] ? "R8" : "R3");
      end

      // R2: store-and-forward waits for the frame end
      cfg_store_fwd = 1'b1; cfg_drop_err = 1'b1;
      for (int i = 0; i < 5; i++) begin
         wr_valid = 1'b1; wr_data = 8'(8'hA0 + i); wr_last = 1'b0; wr_status = 8'h00;
         @(negedge clk);
      end
      wr_valid = 1'b0;
      @(negedge clk);
      chk("R2", "partial frame hidden", int'(rd_valid), 0);
      wr_valid = 1'b1; wr_data = 8'hA5; wr_last = 1'b1; wr_status = 8'h06;
      @(negedge clk);
      wr_valid = 1'b0; wr_last = 1'b0;
      chk("R2", "frame visible after end", int'(rd_valid), 1);
      @(negedge clk); @(negedge clk);
      chk("R7", "offer held", int'(rd_valid), 1);
      chk("R7", "offer stable", int'(rd_data), 8'hA0);
      read_frame("R2", 6, 8'hA0, 9'h006);
      chk_empty("R2");

      // R5: cut-through shows all but the newest byte of an open frame
      cfg_store_fwd = 1'b0;
      for (int i = 0; i < 3; i++) begin
         wr_valid = 1'b1; wr_data = 8'(8'hB0 + i); wr_last = 1'b0;
         @(negedge clk);
      end
      wr_valid = 1'b0;
      chk("R5", "early readout", int'(rd_valid), 1);
      for (int i = 0; i < 2; i++) begin
         pop_byte(ok, d, f, l);
         chk("R5", "early byte", int'(d), 8'hB0 + i);
         chk("R5", "early byte not last", int'(l), 0);
      end
      chk("R5", "newest byte held back", int'(rd_valid), 0);
      wr_valid = 1'b1; wr_data = 8'hB3; wr_last = 1'b1; wr_status = 8'h08;
      @(negedge clk);
      wr_valid = 1'b0; wr_last = 1'b0;
      pop_byte(ok, d, f, l);
      chk("R5", "third byte", int'(d), 8'hB2);
      pop_byte(ok, d, f, l);
      chk("R5", "final byte", int'(d), 8'hB3);
      chk("R5", "final flag", int'(l), 1);
      pop_stat("R5", 9'h008);
      chk_empty("R5");

      // R9: overflow partway through a frame, reader stalled
      write_frame(20, 8'hC0, 8'h00, nd, fd);
      chk("R9", "drop pulse count", nd, 1);
      chk("R9", "drop pulse position", fd, 16);
      read_frame("R9", 16, 8'hC0, 9'h100);
      chk_empty("R9");

      // R10 + R11: status queue full at frame start, frames kept in order
      cfg_store_fwd = 1'b1;
      for (int k = 0; k < 4; k++) begin
         write_frame(2, 8'h10 * k + 8'h04, 8'(8'h10 + k * 2), nd, fd);
         chk("R11", "queued frame accepted", nd, 0);
      end
      write_frame(2, 8'hEE, 8'h00, nd, fd);
      chk("R10", "status queue full drop", nd, 1);
      chk("R10", "drop at first byte", fd, 0);
      for (int k = 0; k < 4; k++)
         read_frame("R11", 2, 8'h10 * k + 8'h04, 8'h10 + k * 2);
      chk_empty("R10");

      // R10: byte buffer full at frame start
      write_frame(16, 8'hD0, 8'h0A, nd, fd);
      chk("R10", "exact fill accepted", nd, 0);
      write_frame(2, 8'hF0, 8'h00, nd, fd);
      chk("R10", "buffer full drop", nd, 1);
      read_frame("R10", 16, 8'hD0, 9'h00A);
      chk_empty("R10");

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule